// File: doc/BRIEF.md
# Current-Adaptive Clamping Three-Phase PWM Modulator

This block drives the three legs of a two-level inverter with a discontinuous modulation that decides, once per switching period, which leg is held to a DC rail. The choice follows the reference currents rather than a fixed voltage-angle pattern. Each period it takes three signed phase voltage references and three signed phase current references as fixed-point samples. It first rules out the leg whose voltage reference lies between the other two, because clamping that leg would drive another leg past a rail. Of the two legs left, it keeps the one whose current reference has the larger magnitude. That leg is clamped to the positive rail when its voltage reference is positive and to the negative rail otherwise.

The block adds one common offset to all three references, so line-to-line voltages are unchanged. It saturates each shifted reference to the rail range and scales it into a duty count. It compares the three duty counts with one shared triangular carrier to produce three complementary gate pairs. Duties are taken only at the carrier valley, so a period never sees a duty change, and the clamped leg does not switch for that whole period. The index and polarity of the clamped leg are exposed for observation. Dead time, current control and sensing belong to other blocks.

Top module: `adaptive_clamp_pwm`

## Requirements
- R1: The leg whose voltage reference lies between the other two, counting ties as between and taking the lowest leg index if several qualify, is never chosen for clamping.
- R2: Of the two remaining legs, the one whose current reference has the larger absolute value is clamped. On equal magnitudes the lower leg index wins. Leg index 0 is phase a, 1 is b and 2 is c.
- R3: The clamp polarity is positive (clamp_pos = 1) when the chosen leg's voltage reference is strictly greater than zero, and negative (clamp_pos = 0) otherwise. clamp_leg and clamp_pos are updated at the same valley as the duties.
- R4: A common offset of +VHALF or -VHALF minus the chosen leg's voltage is added to all three references, where VHALF = 2^VSH. Each shifted reference is then saturated to the range -VHALF to +VHALF.
- R5: Each leg's duty count is floor((s + VHALF) * CMAX / (2 * VHALF)), where s is the saturated shifted reference, so the duty count lies in 0 to CMAX.
- R6: The carrier counts 0, 1, …, CMAX-1 and then CMAX-1, …, 0, giving a period of 2*CMAX clocks. gate_hi of a leg is 1 exactly when its duty count is greater than the carrier, and gate_lo is always the complement of gate_hi.
- R7: The clamped leg's gate_hi stays constant at clamp_pos for every clock of the period.
- R8: New inputs are taken only on the clock edge that leaves the carrier valley, which is the first state of a period. Input changes within a period have no effect on the gates until the next valley.
- R9: While reset is asserted and until the first valley, gate_hi is 000, gate_lo is 111, clamp_leg is 0 and clamp_pos is 0, and the carrier is at its valley.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst | input | 1 | Synchronous active-high reset |
| v_ref_a | input | DW | Signed voltage reference, phase a |
| v_ref_b | input | DW | Signed voltage reference, phase b |
| v_ref_c | input | DW | Signed voltage reference, phase c |
| i_ref_a | input | DW | Signed current reference, phase a |
| i_ref_b | input | DW | Signed current reference, phase b |
| i_ref_c | input | DW | Signed current reference, phase c |
| gate_hi | output | 3 | Upper switch commands, bit k for leg k |
| gate_lo | output | 3 | Lower switch commands, complement of gate_hi |
| clamp_leg | output | 2 | Index of the leg clamped this period |
| clamp_pos | output | 1 | 1 for a positive-rail clamp, 0 for a negative-rail clamp |

## Verification
The assertions assume that the references are settled on the clock edge that leaves the valley. They do not assume the references fit inside the rail range, since saturation is part of the block's job. They also assume the current references stay within DW bits, so their magnitudes cannot overflow. The stimulus changes inputs only on falling clock edges. Random voltages mostly stay within a linear range, and directed cases push the shifted references past the rails and create voltage and current ties on purpose. One directed period changes the inputs halfway through, to show that the gates ignore the change until the next valley.

// File: rtl/acp_pkg.sv
package acp_pkg;

    typedef enum logic [1:0] {
        LEG_A = 2'd0,
        LEG_B = 2'd1,
        LEG_C = 2'd2
    } leg_e;

    typedef struct packed {
        leg_e leg;
        logic pos;
    } clamp_t;

    function automatic int iabs(input int x);
        return (x < 0) ? -x : x;
    endfunction

    // true when x sits between p and q (inclusive), in either order
    function automatic logic is_between(input int x, input int p, input int q);
        return ((x >= p) && (x <= q)) || ((x <= p) && (x >= q));
    endfunction

    function automatic int clip(input int x, input int lim);
        if (x > lim)  return lim;
        if (x < -lim) return -lim;
        return x;
    endfunction

endpackage

// File: rtl/acp_carrier.sv
module acp_carrier #(
    parameter int CMAX = 100,
    parameter int CW   = $clog2(CMAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [CW-1:0] carrier,
    output logic          load
);

    logic [CW-1:0] cnt_q;
    logic          up_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else if (up_q) begin
            if (cnt_q == CW'(CMAX - 1)) up_q  <= 1'b0;
            else                        cnt_q <= cnt_q + 1'b1;
        end else begin
            if (cnt_q == '0) up_q  <= 1'b1;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign carrier = cnt_q;
    assign load    = up_q && (cnt_q == '0);

    a_r6_carrier_range: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(CMAX - 1));

    a_r6_carrier_step: assert property (@(posedge clk) disable iff (rst)
        !load |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1)
                  || (cnt_q == $past(cnt_q) - 1'b1));

    a_r8_single_valley: assert property (@(posedge clk) disable iff (rst)
        load |=> !load);

endmodule

// File: rtl/acp_leg_select.sv
module acp_leg_select
    import acp_pkg::*;
#(
    parameter int DW  = 16,
    parameter int VSH = 12
) (
    input  logic signed [DW-1:0] v_ref [3],
    input  logic signed [DW-1:0] i_ref [3],
    output clamp_t               choice,
    output logic [1:0]           mid_leg,
    output logic signed [DW+1:0] offset
);

    localparam int VHALF = 1 << VSH;

    int   vi [3];
    int   mag0, mag1, vsel, off_i;
    logic [1:0] cand0, cand1, pick;

    always_comb begin
        for (int k = 0; k < 3; k++) vi[k] = int'(v_ref[k]);

        // descending scan so the lowest qualifying index is kept
        mid_leg = 2'd0;
        for (int k = 2; k >= 0; k--) begin
            if (is_between(vi[k], vi[(k + 1) % 3], vi[(k + 2) % 3]))
                mid_leg = 2'(k);
        end

        unique case (mid_leg)
            2'd0:    begin cand0 = 2'd1; cand1 = 2'd2; end
            2'd1:    begin cand0 = 2'd0; cand1 = 2'd2; end
            default: begin cand0 = 2'd0; cand1 = 2'd1; end
        endcase

        mag0 = iabs(int'(i_ref[cand0]));
        mag1 = iabs(int'(i_ref[cand1]));
        pick = (mag1 > mag0) ? cand1 : cand0;

        vsel       = int'(v_ref[pick]);
        choice.leg = leg_e'(pick);
        choice.pos = (vsel > 0);
        off_i      = (choice.pos ? VHALF : -VHALF) - vsel;
        offset     = (DW+2)'(off_i);
    end

endmodule

// File: rtl/acp_leg.sv
module acp_leg
    import acp_pkg::*;
#(
    parameter int DW   = 16,
    parameter int VSH  = 12,
    parameter int CMAX = 100,
    parameter int CW   = $clog2(CMAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic signed [DW-1:0] v_ref,
    input  logic signed [DW+1:0] offset,
    input  logic [CW-1:0]        carrier,
    output logic                 gate_hi
);

    localparam int VHALF = 1 << VSH;

    int            shifted, sat, prod;
    logic [CW-1:0] duty_n, duty_q;

    always_comb begin
        shifted = int'(v_ref) + int'(offset);
        sat     = clip(shifted, VHALF);
        prod    = (sat + VHALF) * CMAX;
        duty_n  = CW'(prod >> (VSH + 1));
    end

    always_ff @(posedge clk) begin
        if (rst)       duty_q <= '0;
        else if (load) duty_q <= duty_n;
    end

    assign gate_hi = (duty_q > carrier);

    a_r5_duty_range: assert property (@(posedge clk) disable iff (rst)
        duty_q <= CW'(CMAX));

    a_r8_duty_hold: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(duty_q));

endmodule

// File: rtl/adaptive_clamp_pwm.sv
module adaptive_clamp_pwm
    import acp_pkg::*;
#(
    parameter int DW   = 16,
    parameter int VSH  = 12,
    parameter int CMAX = 100,
    parameter int CW   = $clog2(CMAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [DW-1:0] v_ref_a,
    input  logic signed [DW-1:0] v_ref_b,
    input  logic signed [DW-1:0] v_ref_c,
    input  logic signed [DW-1:0] i_ref_a,
    input  logic signed [DW-1:0] i_ref_b,
    input  logic signed [DW-1:0] i_ref_c,
    output logic [2:0]           gate_hi,
    output logic [2:0]           gate_lo,
    output logic [1:0]           clamp_leg,
    output logic                 clamp_pos
);

    logic signed [DW-1:0] v_arr [3];
    logic signed [DW-1:0] i_arr [3];
    logic [CW-1:0]        carrier;
    logic                 load;
    clamp_t               choice, clamp_q;
    logic [1:0]           mid_leg;
    logic signed [DW+1:0] offset;

    assign v_arr[0] = v_ref_a;
    assign v_arr[1] = v_ref_b;
    assign v_arr[2] = v_ref_c;
    assign i_arr[0] = i_ref_a;
    assign i_arr[1] = i_ref_b;
    assign i_arr[2] = i_ref_c;

    acp_carrier #(.CMAX(CMAX), .CW(CW)) u_carrier (
        .clk     (clk),
        .rst     (rst),
        .carrier (carrier),
        .load    (load)
    );

    acp_leg_select #(.DW(DW), .VSH(VSH)) u_select (
        .v_ref   (v_arr),
        .i_ref   (i_arr),
        .choice  (choice),
        .mid_leg (mid_leg),
        .offset  (offset)
    );

    for (genvar g = 0; g < 3; g++) begin : g_leg
        acp_leg #(.DW(DW), .VSH(VSH), .CMAX(CMAX), .CW(CW)) u_leg (
            .clk     (clk),
            .rst     (rst),
            .load    (load),
            .v_ref   (v_arr[g]),
            .offset  (offset),
            .carrier (carrier),
            .gate_hi (gate_hi[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)       clamp_q <= '{leg: LEG_A, pos: 1'b0};
        else if (load) clamp_q <= choice;
    end

    assign gate_lo   = ~gate_hi;
    assign clamp_leg = clamp_q.leg;
    assign clamp_pos = clamp_q.pos;

    // magnitudes of the chosen leg and the leg that was neither mid nor chosen
    logic [1:0] other_leg;
    int         mag_sel, mag_oth;
    always_comb begin
        other_leg = 2'd3 - mid_leg - choice.leg;
        mag_sel   = iabs(int'(i_arr[choice.leg]));
        mag_oth   = iabs(int'(i_arr[other_leg]));
    end

    a_r1_mid_not_clamped: assert property (@(posedge clk) disable iff (rst)
        load |-> (2'(choice.leg) != mid_leg));

    a_r2_larger_current: assert property (@(posedge clk) disable iff (rst)
        load |-> (mag_sel >= mag_oth));

    a_r3_latched_choice: assert property (@(posedge clk) disable iff (rst)
        load |=> (clamp_leg == 2'($past(choice.leg))) && (clamp_pos == $past(choice.pos)));

    a_r7_clamped_static: assert property (@(posedge clk) disable iff (rst)
        gate_hi[clamp_leg] == clamp_pos);

endmodule

// File: tb/adaptive_clamp_pwm_tb.sv
module adaptive_clamp_pwm_tb;

    localparam int DW    = 16;
    localparam int VSH   = 12;
    localparam int CMAX  = 100;
    localparam int VHALF = 1 << VSH;
    localparam int PER   = 2 * CMAX;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic signed [DW-1:0] va, vb, vc, ia, ib, ic;
    logic [2:0] gate_hi, gate_lo;
    logic [1:0] clamp_leg;
    logic       clamp_pos;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    adaptive_clamp_pwm #(.DW(DW), .VSH(VSH), .CMAX(CMAX)) u_dut (
        .clk(clk), .rst(rst),
        .v_ref_a(va), .v_ref_b(vb), .v_ref_c(vc),
        .i_ref_a(ia), .i_ref_b(ib), .i_ref_c(ic),
        .gate_hi(gate_hi), .gate_lo(gate_lo),
        .clamp_leg(clamp_leg), .clamp_pos(clamp_pos)
    );

    function automatic int babs(int x);
        return x < 0 ? -x : x;
    endfunction

    // R1: median leg by counting neighbours strictly above and below
    function automatic int exp_mid(int v[3]);
        for (int k = 0; k < 3; k++) begin
            int lt = 0, gt = 0;
            for (int j = 0; j < 3; j++) begin
                if (j != k && v[j] < v[k]) lt++;
                if (j != k && v[j] > v[k]) gt++;
            end
            if (lt <= 1 && gt <= 1) return k;
        end
        return 0;
    endfunction

    // R2
    function automatic int exp_leg(int v[3], int i[3]);
        int m = exp_mid(v);
        int best = -1;
        for (int k = 0; k < 3; k++) begin
            if (k != m) begin
                if (best < 0 || babs(i[k]) > babs(i[best])) best = k;
            end
        end
        return best;
    endfunction

    // R4, R5
    function automatic int exp_duty(int v[3], int i[3], int k);
        int c   = exp_leg(v, i);
        int off = ((v[c] > 0) ? VHALF : -VHALF) - v[c];
        int s   = v[k] + off;
        if (s > VHALF)  s = VHALF;
        if (s < -VHALF) s = -VHALF;
        return ((s + VHALF) * CMAX) / (2 * VHALF);
    endfunction

    function automatic int car_at(int p);
        return (p < CMAX) ? p : (PER - 1 - p);
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic drive(int v[3], int i[3]);
        va = DW'(v[0]); vb = DW'(v[1]); vc = DW'(v[2]);
        ia = DW'(i[0]); ib = DW'(i[1]); ic = DW'(i[2]);
    endtask

    // called at the falling edge of a valley state; covers one period
    task automatic run_period(int v[3], int i[3], bit disturb);
        int ed[3];
        int el, bad[3], badlo;
        bit ep;
        drive(v, i);
        el = exp_leg(v, i);
        ep = (v[el] > 0);
        for (int k = 0; k < 3; k++) begin
            ed[k]  = exp_duty(v, i, k);
            bad[k] = 0;
        end
        badlo = 0;
        @(posedge clk);
        for (int t = 1; t <= PER; t++) begin
            @(negedge clk);
            if (t == 1) begin
                check(clamp_leg == 2'(el), "R1/R2 clamp_leg", int'(clamp_leg), el);
                check(clamp_pos == ep, "R3 clamp_pos", int'(clamp_pos), int'(ep));
            end
            for (int k = 0; k < 3; k++)
                if (gate_hi[k] != (ed[k] > car_at(t % PER))) bad[k]++;
            if (gate_lo != ~gate_hi) badlo++;
            if (disturb && t == CMAX) begin
                int w[3] = '{-v[0], v[2], v[1]};
                int j[3] = '{i[2], -i[0], i[1] * 3};
                drive(w, j);  // R8: must not reach the gates this period
            end
        end
        for (int k = 0; k < 3; k++)
            check(bad[k] == 0, disturb ? "R8 mid-period hold" : "R5/R6 gate pattern",
                  bad[k], 0);
        check(bad[el] == 0, "R7 clamped leg static", bad[el], 0);
        check(badlo == 0, "R6 complementary gate_lo", badlo, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int seed;
        int v[3], i[3];
        seed = 32'h5EED_0A17;
        void'($urandom(seed));
        va = '0; vb = '0; vc = '0; ia = '0; ib = '0; ic = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R9
        check(gate_hi == 3'b000, "R9 reset gate_hi", int'(gate_hi), 0);
        check(gate_lo == 3'b111, "R9 reset gate_lo", int'(gate_lo), 7);
        check(clamp_leg == 2'd0 && clamp_pos == 1'b0, "R9 reset clamp",
              int'({clamp_leg, clamp_pos}), 0);
        rst = 1'b0;

        // R1 R2 R3: balanced case, phase a carries the most current
        v = '{3000, -1000, -2000}; i = '{100, -50, -50};
        run_period(v, i, 1'b0);
        // R1: largest current sits on the median leg, second largest decides
        v = '{3000, -1000, -2000}; i = '{10, 900, -20};
        run_period(v, i, 1'b0);
        // R2: equal magnitudes, lower index wins
        v = '{3000, -1000, -2000}; i = '{50, 0, -50};
        run_period(v, i, 1'b0);
        // R3: chosen voltage of zero goes to the negative rail
        v = '{0, 0, 0}; i = '{0, 5, 5};
        run_period(v, i, 1'b0);
        // R4: saturation of a shifted reference beyond the rail
        v = '{8000, -8000, 0}; i = '{1000, 0, 0};
        run_period(v, i, 1'b0);
        // R3: negative clamp with positive median
        v = '{-3500, 1500, 2000}; i = '{-700, 20, 600};
        run_period(v, i, 1'b0);
        // R8: inputs change in the middle of a period
        v = '{2500, -500, -2000}; i = '{-300, 40, 200};
        run_period(v, i, 1'b1);
        v = '{-1200, 3900, -2700}; i = '{400, -400, 100};
        run_period(v, i, 1'b0);

        for (int n = 0; n < 300; n++) begin
            for (int k = 0; k < 3; k++) begin
                v[k] = int'($urandom_range(7400)) - 3700;
                i[k] = int'($urandom_range(4000)) - 2000;
            end
            if (n % 10 == 3) i[2] = -i[0];
            if (n % 10 == 7) v[1] = v[0];
            run_period(v, i, (n % 25) == 11);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule